// File: doc/BRIEF.md
# Serial Program/Verify Target Interface

This block is the device-side logic of a two-wire serial programming port. An external programmer toggles a serial clock and moves bits on a single data wire. Here that wire is split into a data input, a data output and an output enable. The block samples both wires with its own system clock and detects the serial clock edges. It collects 6-bit commands and handles the 16-cycle data frames that follow load and read commands. It drives a word-addressed memory port: a 14-bit address, a write word and a write strobe. It also takes back a read word.

The address counter starts at zero in user space. Increments wrap inside the implemented user memory, whose size is a power-of-two parameter. A load-configuration command moves the counter to the configuration window at 0x2000. From there, increments only advance the low 13 bits, and the window cannot be left. The only way out is to drop the program-mode level input. While that input is low, all framing, counter and strobe state is held in reset.

Top module: `pgm_serial_target`

## Requirements
- R1: A command is six serial clock cycles; the data input is captured on each falling serial clock edge, least significant bit first, and the code is acted on after the sixth falling edge.
- R2: Command codes (value of the six bits, bit 0 sent first): 0x00 load configuration, 0x02 load data, 0x04 read data, 0x06 increment address, 0x08 begin programming, 0x0E end programming.
- R3: A load frame is 16 serial cycles. The values on the falling edges of cycles 1 and 16 (start and stop) are discarded. Falling edges 2 through 15 supply data bits 0 through 13, and the word appears on the write-word output once the frame ends.
- R4: In a read frame, the output enable rises after the second rising serial edge with bit 0 of the read word on the data output. Bit k is presented after rising edge k+2, and the enable falls after the sixteenth rising edge.
- R5: In user space, increment address steps the address modulo USER_WORDS, so the address never reaches USER_WORDS.
- R6: Load configuration sets the address to 0x2000. After that, bit 13 stays 1, and increments advance only bits 12..0, until program mode is left.
- R7: Begin programming after a load raises the write strobe with the last loaded word. The strobe stays high until end programming, and the load is consumed.
- R8: Begin programming with no load since the previous begin (or since entry) leaves the write strobe low.
- R9: Codes other than the six of R2 change no address, strobe or pending load. The next six bits are taken as a new command.
- R10: While the program-mode input is low, the address is 0, the strobe and output enable are low, and any partial command or frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| prog_en | input | 1 | Program-mode level; low holds the block in reset |
| sck | input | 1 | Serial clock from the programmer |
| sdi | input | 1 | Serial data from the programmer |
| sdo | output | 1 | Serial data toward the programmer |
| sdo_oe | output | 1 | Drive enable for the shared data pin |
| mem_addr | output | 14 | Word address (bit 13 selects configuration space) |
| mem_wdata | output | 14 | Word to be programmed |
| mem_we | output | 1 | Write strobe, high for the programming pulse |
| mem_rdata | input | 14 | Word read from the addressed location |

## Verification
The bench builds the block with USER_WORDS = 16 and SYNC_STAGES = 2. At that size, every user word can be written with its own computed value and read back. The wrap from the last word to zero is reached after sixteen increments instead of thousands. It also leaves room to walk the configuration window past 0x2010, which confirms that the user-size mask never pulls the counter back out of it.

// File: rtl/pgm_serial_pkg.sv
package pgm_serial_pkg;
   localparam int CMD_W     = 6;
   localparam int WORD_W    = 14;
   localparam int ADDR_W    = 14;
   localparam int FRAME_LEN = 16;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [ADDR_W-1:0] CFG_BASE = 14'h2000;

   typedef enum logic [CMD_W-1:0] {
      CMD_LD_CFG = 6'h00,
      CMD_LD_DAT = 6'h02,
      CMD_RD_DAT = 6'h04,
      CMD_INC    = 6'h06,
      CMD_BEGIN  = 6'h08,
      CMD_END    = 6'h0E
   } cmd_e;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_LOAD,
      PH_READ
   } phase_e;

   function automatic phase_e phase_after(input logic [CMD_W-1:0] code);
      case (code)
         CMD_LD_CFG, CMD_LD_DAT: phase_after = PH_LOAD;
         CMD_RD_DAT:             phase_after = PH_READ;
         default:                phase_after = PH_CMD;
      endcase
   endfunction
endpackage

// File: rtl/pgm_edge_sync.sv
module pgm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic sdi_i,
   output logic rise_o,
   output logic fall_o,
   output logic sdi_o
);
   logic sck_s;
   logic sck_d;

   generate
      if (STAGES > 0) begin : g_sync
         logic [STAGES-1:0] sck_q;
         logic [STAGES-1:0] sdi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q <= '0;
               sdi_q <= '0;
            end else begin
               sck_q[0] <= sck_i;
               sdi_q[0] <= sdi_i;
               for (int i = 1; i < STAGES; i++) begin
                  sck_q[i] <= sck_q[i-1];
                  sdi_q[i] <= sdi_q[i-1];
               end
            end
         end
         assign sck_s = sck_q[STAGES-1];
         assign sdi_o = sdi_q[STAGES-1];
      end else begin : g_direct
         assign sck_s = sck_i;
         assign sdi_o = sdi_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise_o = sck_s & ~sck_d;
   assign fall_o = ~sck_s & sck_d;
endmodule

// File: rtl/pgm_frame.sv
module pgm_frame
   import pgm_serial_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   input  logic [WORD_W-1:0] rd_word,
   output logic              cmd_stb,
   output logic [CMD_W-1:0]  cmd_code,
   output logic              ld_stb,
   output logic [WORD_W-1:0] ld_word,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam logic [CNT_W-1:0] K_ONE        = CNT_W'(1);
   localparam logic [CNT_W-1:0] K_TWO        = CNT_W'(2);
   localparam logic [CNT_W-1:0] K_CMD_LAST   = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] K_DATA_LAST  = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] K_FRAME_LAST = CNT_W'(FRAME_LEN - 1);

   phase_e            phase;
   logic [CNT_W-1:0]  fcnt;
   logic [CNT_W-1:0]  rcnt;
   logic [CMD_W-1:0]  csr;
   logic [WORD_W-1:0] lsr;
   logic [WORD_W-1:0] osr;
   logic [CMD_W-1:0]  cmd_next;

   assign cmd_next = {sdi, csr[CMD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         fcnt     <= '0;
         rcnt     <= '0;
         csr      <= '0;
         lsr      <= '0;
         osr      <= '0;
         cmd_stb  <= 1'b0;
         cmd_code <= '0;
         ld_stb   <= 1'b0;
         ld_word  <= '0;
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
      end else begin
         cmd_stb <= 1'b0;
         ld_stb  <= 1'b0;
         if (clr) begin
            phase  <= PH_CMD;
            fcnt   <= '0;
            rcnt   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
         end else begin
            case (phase)
               PH_CMD: begin
                  if (fall) begin
                     csr <= cmd_next;
                     if (fcnt == K_CMD_LAST) begin
                        fcnt     <= '0;
                        rcnt     <= '0;
                        cmd_stb  <= 1'b1;
                        cmd_code <= cmd_next;
                        phase    <= phase_after(cmd_next);
                     end else begin
                        fcnt <= fcnt + K_ONE;
                     end
                  end
               end
               PH_LOAD: begin
                  if (fall) begin
                     if (fcnt >= K_ONE && fcnt <= K_DATA_LAST)
                        lsr <= {sdi, lsr[WORD_W-1:1]};
                     if (fcnt == K_FRAME_LAST) begin
                        phase   <= PH_CMD;
                        fcnt    <= '0;
                        ld_stb  <= 1'b1;
                        ld_word <= lsr;
                     end else begin
                        fcnt <= fcnt + K_ONE;
                     end
                  end
               end
               PH_READ: begin
                  if (rise) begin
                     rcnt <= rcnt + K_ONE;
                     if (rcnt == K_ONE) begin
                        sdo_oe <= 1'b1;
                        sdo    <= rd_word[0];
                        osr    <= rd_word >> 1;
                     end else if (rcnt >= K_TWO && rcnt <= K_DATA_LAST) begin
                        sdo <= osr[0];
                        osr <= osr >> 1;
                     end else if (rcnt == K_FRAME_LAST) begin
                        sdo_oe <= 1'b0;
                     end
                  end
                  if (fall) begin
                     if (fcnt == K_FRAME_LAST) begin
                        phase  <= PH_CMD;
                        fcnt   <= '0;
                        sdo_oe <= 1'b0;
                     end else begin
                        fcnt <= fcnt + K_ONE;
                     end
                  end
               end
               default: phase <= PH_CMD;
            endcase
         end
      end
   end
endmodule

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr
   import pgm_serial_pkg::*;
#(
   parameter int USER_WORDS = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              set_cfg,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int UW = $clog2(USER_WORDS);

   logic [UW-1:0]       u_inc;
   logic [ADDR_W-2:0]   c_inc;
   logic [ADDR_W-1:0]   nxt;

   assign u_inc = addr_o[UW-1:0] + UW'(1);
   assign c_inc = addr_o[ADDR_W-2:0] + (ADDR_W-1)'(1);

   always_comb begin
      if (addr_o[ADDR_W-1]) nxt = {1'b1, c_inc};
      else                  nxt = {{(ADDR_W-UW){1'b0}}, u_inc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_o <= '0;
      else if (clr)     addr_o <= '0;
      else if (set_cfg) addr_o <= CFG_BASE;
      else if (inc)     addr_o <= nxt;
   end
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
   import pgm_serial_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cmd_stb,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic              ld_stb,
   input  logic [WORD_W-1:0] ld_word,
   output logic              set_cfg,
   output logic              inc,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata
);
   logic armed;
   logic go_begin;
   logic go_end;

   always_comb begin
      set_cfg  = cmd_stb && (cmd_code == CMD_LD_CFG);
      inc      = cmd_stb && (cmd_code == CMD_INC);
      go_begin = cmd_stb && (cmd_code == CMD_BEGIN);
      go_end   = cmd_stb && (cmd_code == CMD_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         armed     <= 1'b0;
         mem_wdata <= '0;
      end else if (clr) begin
         mem_we <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (ld_stb) begin
            mem_wdata <= ld_word;
            armed     <= 1'b1;
         end
         if (go_begin && armed) begin
            mem_we <= 1'b1;
            armed  <= 1'b0;
         end
         if (go_end) mem_we <= 1'b0;
      end
   end
endmodule

// File: rtl/pgm_serial_target.sv
module pgm_serial_target
   import pgm_serial_pkg::*;
#(
   parameter int USER_WORDS  = 2048,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prog_en,
   input  logic        sck,
   input  logic        sdi,
   output logic        sdo,
   output logic        sdo_oe,
   output logic [13:0] mem_addr,
   output logic [13:0] mem_wdata,
   output logic        mem_we,
   input  logic [13:0] mem_rdata
);
   generate
      if (USER_WORDS < 2 || USER_WORDS > 8192 ||
          (USER_WORDS & (USER_WORDS - 1)) != 0) begin : g_bad_words
         $error("USER_WORDS must be a power of two from 2 to 8192");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              clr;
   logic              rise;
   logic              fall;
   logic              sdi_s;
   logic              cmd_stb;
   logic [CMD_W-1:0]  cmd_code;
   logic              ld_stb;
   logic [WORD_W-1:0] ld_word;
   logic              set_cfg;
   logic              inc;

   assign clr = ~prog_en;

   pgm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_i  (sck),
      .sdi_i  (sdi),
      .rise_o (rise),
      .fall_o (fall),
      .sdi_o  (sdi_s)
   );

   pgm_frame u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .rise     (rise),
      .fall     (fall),
      .sdi      (sdi_s),
      .rd_word  (mem_rdata),
      .cmd_stb  (cmd_stb),
      .cmd_code (cmd_code),
      .ld_stb   (ld_stb),
      .ld_word  (ld_word),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   pgm_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .cmd_stb   (cmd_stb),
      .cmd_code  (cmd_code),
      .ld_stb    (ld_stb),
      .ld_word   (ld_word),
      .set_cfg   (set_cfg),
      .inc       (inc),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata)
   );

   pgm_addr_ctr #(.USER_WORDS(USER_WORDS)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .set_cfg (set_cfg),
      .inc     (inc),
      .addr_o  (mem_addr)
   );
endmodule

// File: rtl/pgm_serial_target_chk.sv
module pgm_serial_target_chk #(
   parameter int USER_WORDS = 2048
) (
   input logic        clk,
   input logic        rst_n,
   input logic        prog_en,
   input logic        sdo_oe,
   input logic        mem_we,
   input logic [13:0] mem_addr
);
   function automatic logic [13:0] step_of(input logic [13:0] a);
      if (a[13]) step_of = {1'b1, a[12:0] + 13'd1};
      else       step_of = (a + 14'd1) & 14'(USER_WORDS - 1);
   endfunction

   // R10
   exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en |=> (mem_addr == 14'd0 && !mem_we && !sdo_oe));

   // R6
   cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && mem_addr[13]) |=> (mem_addr[13] || !prog_en));

   // R5
   user_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_addr[13] |-> (mem_addr < 14'(USER_WORDS)));

   // R5 R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && $past(prog_en) && (mem_addr != $past(mem_addr)))
      |-> (mem_addr == 14'h2000 || mem_addr == step_of($past(mem_addr))));
endmodule

bind pgm_serial_target pgm_serial_target_chk #(.USER_WORDS(USER_WORDS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .prog_en  (prog_en),
   .sdo_oe   (sdo_oe),
   .mem_we   (mem_we),
   .mem_addr (mem_addr)
);

// File: tb/sim_pgm_serial_target.sv
`timescale 1ns/1ps
module sim_pgm_serial_target;
   localparam int UWORDS = 16;
   localparam int H      = 6;

   logic        clk = 1'b0;
   logic        rst_n, prog_en, sck, sdi;
   logic        sdo, sdo_oe, mem_we;
   logic [13:0] mem_addr, mem_wdata, mem_rdata;

   logic [13:0] umem [UWORDS];
   logic [13:0] cmem [16];
   logic [13:0] expu [UWORDS];

   int  compared = 0;
   int  mismatched = 0;
   bit  done = 0;

   always #4 clk = ~clk;

   pgm_serial_target #(.USER_WORDS(UWORDS), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem_addr[13] ? cmem[mem_addr[3:0]] : umem[mem_addr[3:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < UWORDS; i++) umem[i] <= '0;
         for (int i = 0; i < 16; i++) cmem[i] <= '0;
      end else if (mem_we) begin
         if (mem_addr[13]) cmem[mem_addr[3:0]] <= mem_wdata;
         else              umem[mem_addr[3:0]] <= mem_wdata;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk(input logic b);
      sdi = b;
      sck = 1'b1;
      waitc(H);
      sck = 1'b0;
      waitc(H);
   endtask

   task automatic cmd(input logic [5:0] code);
      for (int i = 0; i < 6; i++) sclk(code[i]);
      sdi = 1'b0;
      waitc(4);
   endtask

   task automatic load(input logic [13:0] w, input logic st, input logic sp);
      sclk(st);
      for (int i = 0; i < 14; i++) sclk(w[i]);
      sclk(sp);
      sdi = 1'b0;
      waitc(4);
   endtask

   task automatic rd(output logic [13:0] w, output bit ok);
      w  = '0;
      ok = 1'b1;
      for (int c = 1; c <= 16; c++) begin
         sdi = 1'b0;
         sck = 1'b1;
         waitc(H);
         if (c == 1 || c == 16) begin
            if (sdo_oe) ok = 1'b0;
         end else begin
            if (!sdo_oe) ok = 1'b0;
            w[c-2] = sdo;
         end
         sck = 1'b0;
         waitc(H);
      end
      if (sdo_oe) ok = 1'b0;
      waitc(4);
   endtask

   function automatic logic [13:0] val(input int a);
      return 14'((32'h2A5 + a * 32'h1B3) & 32'h3FFF);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [13:0] w;
      bit          ok;
      int          unk [8] = '{1, 3, 5, 7, 10, 12, 16, 63};
      rst_n = 1'b0; prog_en = 1'b0; sck = 1'b0; sdi = 1'b0;
      waitc(5);
      rst_n = 1'b1;
      waitc(3);
      chk("R10 reset addr", mem_addr, 0);
      chk("R10 reset we", mem_we, 0);
      chk("R10 reset oe", sdo_oe, 0);
      prog_en = 1'b1;
      waitc(3);

      // R8: begin with nothing loaded
      cmd(6'h08);
      chk("R8 begin without load", mem_we, 0);
      cmd(6'h0E);

      // R1 R2 R3 R5 R7: write sweep over every user word, wrap at the end
      for (int a = 0; a < UWORDS; a++) begin
         cmd(6'h02);
         load(val(a), a[0], ~a[0]);
         chk("R3 load word", mem_wdata, val(a));
         chk("R7 no strobe before begin", mem_we, 0);
         cmd(6'h08);
         chk("R7 strobe on begin", mem_we, 1);
         chk("R5 addr at write", mem_addr, a);
         if (a == 5) begin
            waitc(40);
            chk("R7 strobe held", mem_we, 1);
         end
         cmd(6'h0E);
         chk("R7 strobe off at end", mem_we, 0);
         expu[a] = val(a);
         cmd(6'h06);
         chk("R5 increment wrap", mem_addr, (a + 1) % UWORDS);
      end
      cmd(6'h08);
      chk("R7 load consumed by begin", mem_we, 0);

      // R4: read back sweep
      for (int a = 0; a < UWORDS; a++) begin
         cmd(6'h04);
         rd(w, ok);
         chk("R4 output enable window", ok, 1);
         chk("R4 read word", w, expu[a]);
         cmd(6'h06);
      end
      chk("R5 addr back to zero", mem_addr, 0);

      // R9: unknown codes keep the pending load and the address
      cmd(6'h02);
      load(14'h155, 1'b1, 1'b1);
      for (int k = 0; k < 8; k++) begin
         cmd(6'(unk[k]));
         chk("R9 unknown keeps addr", mem_addr, 0);
         chk("R9 unknown keeps strobe", mem_we, 0);
         chk("R9 unknown no drive", sdo_oe, 0);
      end
      cmd(6'h08);
      chk("R9 pending load survives", mem_we, 1);
      cmd(6'h0E);
      expu[0] = 14'h155;

      // R6: configuration window
      cmd(6'h00);
      chk("R6 load config addr", mem_addr, 14'h2000);
      load(14'h3FF5, 1'b1, 1'b1);
      cmd(6'h08);
      cmd(6'h0E);
      for (int k = 0; k < 7; k++) cmd(6'h06);
      chk("R6 config increments", mem_addr, 14'h2007);
      cmd(6'h02);
      load(14'h00C3, 1'b0, 1'b1);
      cmd(6'h08);
      cmd(6'h0E);
      cmd(6'h04);
      rd(w, ok);
      chk("R6 config readback", w, 14'h00C3);
      for (int k = 0; k < 20; k++) cmd(6'h06);
      chk("R6 config sticky", mem_addr, 14'h201B);

      // R10: leave program mode
      prog_en = 1'b0;
      waitc(4);
      chk("R10 exit addr", mem_addr, 0);
      prog_en = 1'b1;
      waitc(4);
      cmd(6'h04);
      rd(w, ok);
      chk("R10 user word after re-entry", w, expu[0]);

      // R1 R10: partial command discarded on exit
      sclk(1'b0); sclk(1'b1); sclk(1'b1);
      prog_en = 1'b0;
      waitc(4);
      prog_en = 1'b1;
      waitc(4);
      cmd(6'h06);
      chk("R1 framing restarts", mem_addr, 1);
      cmd(6'h04);
      rd(w, ok);
      chk("R1 read after restart", w, expu[1]);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule